// File: doc/BRIEF.md
# Packet Command Issue Engine

This block is the host-side sequencer that hands one 12-byte packet command to a device attached through the classic eight-register task-file bus. A caller presents the packet on a wide parallel input, picks the interrupt-disable setting, and pulses `start`. The engine latches both and then drives the whole handshake on the register bus without further help. First it programs the device control register, then it writes the packet opcode. It waits out the settle time after the opcode before the first status read, and it polls until the device asks for the packet. It then writes the packet as six 16-bit words, with a pacing read between words. Finally it reaches the closing status check, either directly or after waiting for the device interrupt line.

The sequence ends in one of two ways. The device may still want data, which leaves a data-phase flag set for whatever logic moves the data. Or the command may be finished, in which case the error bit of the final status is kept for the caller. A single-cycle `done` pulse marks both outcomes. Register reads are combinational: the device side must present the addressed register on `bus_rdata` in the same cycle that `bus_rd` is high.

Top module: `atapi_pkt_engine`

## Requirements
- R1: After reset `busy`, `done`, `bus_rd`, `bus_wr`, `data_phase_req` and `err` are all 0, and `bus_rd` and `bus_wr` are never high together.
- R2: The first bus cycle after an accepted `start` writes select 4'hE (device control) with data bit 1 equal to the latched `nien_cfg` and every other bit 0.
- R3: The next write goes to select 4'h7 (command register) with data 8'hA0.
- R4: The first read of select 4'h7 (status) after the opcode write comes at least SETTLE_CYC cycles later, where SETTLE_CYC = ceil(SETTLE_PS / CLK_PERIOD_PS). At the default 20 ns clock and 400 ns this is 20.
- R5: The engine polls status until bit 7 (busy) is 0 and bit 3 (data request) is 1, and writes no packet word before that.
- R6: The packet is written to select 4'h0 as six words. Input byte n sits on `cmd_pkt[8n+7:8n]`, byte 0 being the opcode, and word k carries byte 2k on bits 7:0 and byte 2k+1 on bits 15:8.
- R7: Exactly one read of select 4'hE (alternate status) lies between any two consecutive packet word writes.
- R8: With the latched interrupt-disable bit at 1, the first read after the last word is one discarded alternate-status read, followed by status polling.
- R9: With that bit at 0, no bus read happens after the last word until `intrq` is high, and the next read is then a status read.
- R10: In the closing check the engine keeps reading status while bit 7 is 1. It makes exactly one more status read once bit 7 is 0.
- R11: A closing status with bit 7 = 0 and bit 3 = 1 ends the command with `done` and `data_phase_req` = 1.
- R12: A closing status with bit 7 = 0 and bit 3 = 0 ends the command with `done` and `data_phase_req` = 0. In both endings `err` equals status bit 0. Both flags hold until the next accepted `start`.
- R13: A `start` pulse while `busy` is 1 is ignored; no second control write is issued.
- R14: `done` is high for exactly one cycle per command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one packet command (accepted only when idle) |
| nien_cfg | input | 1 | Interrupt-disable value to program; selects polled or interrupt path |
| cmd_pkt | input | PKT_BYTES*8 | Packet bytes, byte 0 in the low bits |
| intrq | input | 1 | Device interrupt request |
| bus_sel | output | 4 | Register select: 4'h0 data, 4'h7 status/command, 4'hE alternate status/device control |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | WORD_BYTES*8 | Write data |
| bus_rdata | input | 8 | Status byte returned for the selected register, same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| data_phase_req | output | 1 | Device still requests data after the packet |
| err | output | 1 | Error bit of the final status |

## Verification
The sequence is run with four vectors that cross the two path choices with both endings. The device holds busy for zero to five status polls before asking for the packet and for zero to four polls in the closing check, so any miscounted poll or early exit shows up. Distinct byte patterns in every packet position expose a swapped byte lane or a skipped word. The recorded order of bus events tells the polled path (a leading discarded read) from the interrupt path (silence until the line rises). A stray `start` in the middle of each run shows whether a busy engine can be restarted.

// File: rtl/atapi_pkt_pkg.sv
package atapi_pkt_pkg;
   // register selects {bank, a2..a0}
   localparam logic [3:0] SEL_DATA = 4'h0;
   localparam logic [3:0] SEL_STAT = 4'h7;  // read: status, write: command
   localparam logic [3:0] SEL_ALT  = 4'hE;  // read: alt status, write: device control
   localparam logic [7:0] OPC_PACKET = 8'hA0;
   localparam int ST_BSY   = 7;
   localparam int ST_DRQ   = 3;
   localparam int ST_ERR   = 0;
   localparam int CTL_NIEN = 1;

   typedef enum logic [3:0] {
      S_IDLE, S_CTL, S_CMD, S_SETTLE, S_POLL_A,
      S_SEND, S_PACE, S_ALT_B, S_IRQ, S_CHK_B
   } seq_state_e;
endpackage

// File: rtl/atapi_settle_timer.sv
module atapi_settle_timer #(
   parameter int CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   generate
      if (CYCLES <= 1) begin : g_none
         assign expired = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(CYCLES + 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (load)       cnt <= CW'(CYCLES - 1);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign expired = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/atapi_word_pick.sv
module atapi_word_pick #(
   parameter int PKT_BYTES  = 12,
   parameter int WORD_BYTES = 2,
   parameter int NUM_WORDS  = PKT_BYTES / WORD_BYTES,
   parameter int IDX_W      = $clog2(NUM_WORDS)
) (
   input  logic [PKT_BYTES*8-1:0]  pkt,
   input  logic [IDX_W-1:0]        idx,
   output logic [WORD_BYTES*8-1:0] word
);
   logic [WORD_BYTES*8-1:0] words [NUM_WORDS];

   // low byte first: byte (w*WORD_BYTES + b) lands on lane b
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
         assign words[w][8*b +: 8] = pkt[8*(w*WORD_BYTES + b) +: 8];
      end
   end

   always_comb begin
      word = '0;
      for (int w = 0; w < NUM_WORDS; w++)
         if (idx == IDX_W'(w)) word = words[w];
   end
endmodule

// File: rtl/atapi_pkt_seq.sv
module atapi_pkt_seq
   import atapi_pkt_pkg::*;
#(
   parameter int NUM_WORDS = 6,
   parameter int WORD_W    = 16,
   parameter int IDX_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              nien_cfg,
   input  logic              intrq,
   input  logic [7:0]        stat,
   input  logic              settle_done,
   input  logic [WORD_W-1:0] word,
   output logic [IDX_W-1:0]  idx,
   output logic              capture,
   output logic              settle_load,
   output logic [3:0]        bus_sel,
   output logic              bus_rd,
   output logic              bus_wr,
   output logic [WORD_W-1:0] bus_wdata,
   output logic              busy,
   output logic              done,
   output logic              data_phase_req,
   output logic              err
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

   seq_state_e state;
   logic       nien_q;
   logic       bsy, drq;

   assign bsy = stat[ST_BSY];
   assign drq = stat[ST_DRQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= S_IDLE;
         idx            <= '0;
         nien_q         <= 1'b0;
         done           <= 1'b0;
         data_phase_req <= 1'b0;
         err            <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: if (start) begin
               state          <= S_CTL;
               idx            <= '0;
               nien_q         <= nien_cfg;
               data_phase_req <= 1'b0;
               err            <= 1'b0;
            end
            S_CTL:    state <= S_CMD;
            S_CMD:    state <= S_SETTLE;
            S_SETTLE: if (settle_done) state <= S_POLL_A;
            S_POLL_A: if (!bsy && drq) state <= S_SEND;
            S_SEND: begin
               if (idx == LAST) state <= nien_q ? S_ALT_B : S_IRQ;
               else             state <= S_PACE;
            end
            S_PACE: begin
               idx   <= idx + 1'b1;
               state <= S_SEND;
            end
            S_ALT_B:  state <= S_CHK_B;
            S_IRQ:    if (intrq) state <= S_CHK_B;
            S_CHK_B: if (!bsy) begin
               done           <= 1'b1;
               data_phase_req <= drq;
               err            <= stat[ST_ERR];
               state          <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_sel   = SEL_DATA;
      bus_rd    = 1'b0;
      bus_wr    = 1'b0;
      bus_wdata = '0;
      case (state)
         S_CTL: begin
            bus_wr    = 1'b1;
            bus_sel   = SEL_ALT;
            bus_wdata = {{(WORD_W-CTL_NIEN-1){1'b0}}, nien_q, {CTL_NIEN{1'b0}}};
         end
         S_CMD: begin
            bus_wr    = 1'b1;
            bus_sel   = SEL_STAT;
            bus_wdata = {{(WORD_W-8){1'b0}}, OPC_PACKET};
         end
         S_POLL_A, S_CHK_B: begin
            bus_rd  = 1'b1;
            bus_sel = SEL_STAT;
         end
         S_SEND: begin
            bus_wr    = 1'b1;
            bus_sel   = SEL_DATA;
            bus_wdata = word;
         end
         S_PACE, S_ALT_B: begin
            bus_rd  = 1'b1;
            bus_sel = SEL_ALT;
         end
         default: ;
      endcase
   end

   assign capture     = (state == S_IDLE) && start;
   assign settle_load = (state == S_CMD);
   assign busy        = (state != S_IDLE);
endmodule

// File: rtl/atapi_pkt_engine.sv
module atapi_pkt_engine #(
   parameter int PKT_BYTES     = 12,
   parameter int WORD_BYTES    = 2,
   parameter int CLK_PERIOD_PS = 20000,
   parameter int SETTLE_PS     = 400000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic                    nien_cfg,
   input  logic [PKT_BYTES*8-1:0]  cmd_pkt,
   input  logic                    intrq,
   output logic [3:0]              bus_sel,
   output logic                    bus_rd,
   output logic                    bus_wr,
   output logic [WORD_BYTES*8-1:0] bus_wdata,
   input  logic [7:0]              bus_rdata,
   output logic                    busy,
   output logic                    done,
   output logic                    data_phase_req,
   output logic                    err
);
   localparam int WORD_W     = WORD_BYTES * 8;
   localparam int NUM_WORDS  = PKT_BYTES / WORD_BYTES;
   localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
   localparam int SETTLE_CYC = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

   if (PKT_BYTES % WORD_BYTES != 0) begin : g_bad_split
      $error("packet length must be a whole number of words");
   end
   if (WORD_BYTES < 1) begin : g_bad_word
      $error("word must hold at least one byte");
   end
   if (CLK_PERIOD_PS <= 0) begin : g_bad_clk
      $error("clock period must be positive");
   end

   logic [PKT_BYTES*8-1:0] pkt_q;
   logic [IDX_W-1:0]       idx;
   logic [WORD_W-1:0]      word;
   logic                   capture, settle_load, settle_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pkt_q <= '0;
      else if (capture) pkt_q <= cmd_pkt;
   end

   atapi_word_pick #(
      .PKT_BYTES(PKT_BYTES), .WORD_BYTES(WORD_BYTES),
      .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
   ) u_pick (
      .pkt(pkt_q), .idx(idx), .word(word)
   );

   atapi_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .load(settle_load), .expired(settle_done)
   );

   atapi_pkt_seq #(
      .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .nien_cfg(nien_cfg),
      .intrq(intrq), .stat(bus_rdata), .settle_done(settle_done),
      .word(word), .idx(idx), .capture(capture), .settle_load(settle_load),
      .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .busy(busy), .done(done),
      .data_phase_req(data_phase_req), .err(err)
   );
endmodule

// File: rtl/atapi_pkt_chk.sv
module atapi_pkt_chk
   import atapi_pkt_pkg::*;
#(
   parameter int SETTLE_CYC = 20,
   parameter int NUM_WORDS  = 6,
   parameter int WORD_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              intrq,
   input logic [3:0]        bus_sel,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic [WORD_W-1:0] bus_wdata,
   input logic              done
);
   localparam int GW = $clog2(SETTLE_CYC + 2);
   localparam int NW = $clog2(NUM_WORDS + 1);

   logic          armed, pend, nien_c, irq_wait;
   logic [GW-1:0] since;
   logic [NW-1:0] nw_c;
   logic wr_cmd, wr_dat, rd_alt, rd_stat;

   assign wr_cmd  = bus_wr && bus_sel == SEL_STAT;
   assign wr_dat  = bus_wr && bus_sel == SEL_DATA;
   assign rd_alt  = bus_rd && bus_sel == SEL_ALT;
   assign rd_stat = bus_rd && bus_sel == SEL_STAT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0; since <= '0; pend <= 1'b0;
         nien_c <= 1'b0; irq_wait <= 1'b0; nw_c <= '0;
      end else begin
         if (bus_wr && bus_sel == SEL_ALT) nien_c <= bus_wdata[CTL_NIEN];
         if (wr_cmd) begin
            armed <= 1'b1; since <= GW'(1); pend <= 1'b0;
            nw_c <= '0; irq_wait <= 1'b0;
         end else begin
            if (rd_stat) armed <= 1'b0;
            if (armed && since <= GW'(SETTLE_CYC)) since <= since + 1'b1;
            if (wr_dat) begin
               pend <= 1'b1;
               nw_c <= nw_c + 1'b1;
               if (nw_c == NW'(NUM_WORDS - 1) && !nien_c) irq_wait <= 1'b1;
            end else if (rd_alt) pend <= 1'b0;
            if (intrq) irq_wait <= 1'b0;
         end
      end
   end

   a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));
   a_r3_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd |-> bus_wdata[7:0] == OPC_PACKET);
   a_r4_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && armed) |-> since >= GW'(SETTLE_CYC));
   a_r7_paced_words: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dat |-> !pend);
   a_r9_quiet_until_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_wait && !intrq) |-> !bus_rd);
   a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind atapi_pkt_engine atapi_pkt_chk #(
   .SETTLE_CYC(SETTLE_CYC), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .intrq(intrq), .bus_sel(bus_sel),
   .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .done(done)
);

// File: tb/atapi_pkt_engine_tb_top.sv
module atapi_pkt_engine_tb_top;
   localparam int SETTLE_EXP = 20;  // 400 ns at 20 ns

   logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, nien_cfg = 1'b0, intrq = 1'b0;
   logic [95:0] cmd_pkt = '0;
   logic [3:0]  bus_sel;
   logic        bus_rd, bus_wr, busy, done, data_phase_req, err;
   logic [15:0] bus_wdata;
   logic [7:0]  bus_rdata;

   always #10 clk = ~clk;

   atapi_pkt_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .nien_cfg(nien_cfg),
      .cmd_pkt(cmd_pkt), .intrq(intrq), .bus_sel(bus_sel), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .data_phase_req(data_phase_req), .err(err)
   );

   // device model and bus monitor
   bit   phase;
   int   na_left, nb_left;
   bit   fin_drq, fin_err;
   int   cyc = 0, n_ev, n_ctl, cmd_cyc, stat1_cyc, nw, alt_since, post_n, irq_rd_lo, nb_reads;
   logic [15:0] ctl_val, cmd_val;
   logic [15:0] wlog [6];
   bit   ctl_first, pace_bad, early, post_first_alt;

   always_comb begin
      if (!phase) bus_rdata = (na_left > 0) ? 8'h80 : 8'h48;
      else        bus_rdata = (nb_left > 0) ? 8'h80 :
                              (8'h40 | {4'h0, fin_drq, 3'b000} | {7'h0, fin_err});
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (bus_rd || bus_wr) n_ev <= n_ev + 1;
      if (bus_wr && bus_sel == 4'hE) begin
         n_ctl <= n_ctl + 1; ctl_val <= bus_wdata; ctl_first <= (n_ev == 0);
      end
      if (bus_wr && bus_sel == 4'h7) begin cmd_val <= bus_wdata; cmd_cyc <= cyc; end
      if (bus_rd && bus_sel == 4'h7 && !phase) begin
         if (stat1_cyc < 0) stat1_cyc <= cyc;
         if (na_left > 0) na_left <= na_left - 1;
      end
      if (bus_wr && bus_sel == 4'h0) begin
         if (nw < 6) wlog[nw] <= bus_wdata;
         if (nw > 0 && alt_since != 1) pace_bad <= 1'b1;
         if (na_left > 0) early <= 1'b1;
         alt_since <= 0;
         nw <= nw + 1;
         if (nw == 5) phase <= 1'b1;
      end
      if (bus_rd && bus_sel == 4'hE) alt_since <= alt_since + 1;
      if (phase && bus_rd) begin
         if (post_n == 0) post_first_alt <= (bus_sel == 4'hE);
         post_n <= post_n + 1;
         if (!intrq) irq_rd_lo <= irq_rd_lo + 1;
         if (bus_sel == 4'h7) begin
            nb_reads <= nb_reads + 1;
            if (nb_left > 0) nb_left <= nb_left - 1;
         end
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // {nien, na, nb, drq, err, packet}
   localparam logic [106:0] VECS [4] = '{
      {1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 96'h00000000_00000002_0000001B},
      {1'b0, 4'd3, 4'd2, 1'b0, 1'b1, 96'h0B0A0908_07060504_03020128},
      {1'b1, 4'd5, 4'd4, 1'b1, 1'b0, 96'hFFEEDDCC_BBAA9988_77665543},
      {1'b0, 4'd1, 4'd0, 1'b1, 1'b1, 96'h5A5AA5A5_12345678_9ABCDEF0}
   };

   task automatic run_vec(input logic [106:0] v);
      bit nien = v[106];
      bit drq = v[97], er = v[96];
      logic [95:0] pkt = v[95:0];
      int t = 0, k = 0;
      bit wok = 1'b1;
      @(negedge clk);
      phase = 0; na_left = int'(v[105:102]); nb_left = int'(v[101:98]);
      fin_drq = drq; fin_err = er;
      n_ev = 0; n_ctl = 0; stat1_cyc = -1; nw = 0; alt_since = 0; post_n = 0;
      irq_rd_lo = 0; nb_reads = 0; pace_bad = 0; early = 0; post_first_alt = 0;
      cmd_pkt = pkt; nien_cfg = nien; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done && t < 5000) begin
         if (t == 3) begin start = 1'b1; nien_cfg = ~nien; end   // R13 stray start
         else start = 1'b0;
         if (!nien && phase) begin k++; if (k == 5) intrq = 1'b1; end
         @(negedge clk); t++;
      end
      start = 1'b0;
      chk(done, "R14 done never seen", done, 1);
      chk(data_phase_req == drq, drq ? "R11 data phase" : "R12 data phase", data_phase_req, drq);
      chk(err == er, "R12 err", err, er);
      @(negedge clk);
      chk(!done, "R14 done one cycle", done, 0);
      intrq = 1'b0;
      repeat (3) @(negedge clk);
      chk(data_phase_req == drq && err == er, "R12 flags held",
          {data_phase_req, err}, {drq, er});
      chk(ctl_first && ctl_val == {14'h0, nien, 1'b0}, "R2 control write",
          ctl_val, {14'h0, nien, 1'b0});
      chk(n_ctl == 1, "R13 single control write", n_ctl, 1);
      chk(cmd_val[7:0] == 8'hA0, "R3 opcode", cmd_val, 8'hA0);
      chk(stat1_cyc - cmd_cyc >= SETTLE_EXP, "R4 settle gap", stat1_cyc - cmd_cyc, SETTLE_EXP);
      chk(!early, "R5 word before ready", early, 0);
      for (int w = 0; w < 6; w++)
         if (wlog[w] != {pkt[8*(2*w+1) +: 8], pkt[8*(2*w) +: 8]}) wok = 1'b0;
      chk(wok && nw == 6, "R6 packet words", nw, 6);
      chk(!pace_bad, "R7 pacing read", pace_bad, 0);
      if (nien) chk(post_first_alt, "R8 discarded alt read", post_first_alt, 1);
      else chk(irq_rd_lo == 0 && !post_first_alt, "R9 wait for intrq", irq_rd_lo, 0);
      chk(nb_reads == int'(v[101:98]) + 1, "R10 status polls", nb_reads, int'(v[101:98]) + 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk(!busy && !done && !bus_rd && !bus_wr && !data_phase_req && !err,
          "R1 reset state", {busy, done, bus_rd, bus_wr, data_phase_req, err}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!busy && !bus_rd && !bus_wr, "R1 idle after reset",
          {busy, bus_rd, bus_wr}, 0);
      for (int i = 0; i < 4; i++) run_vec(VECS[i]);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule